// File: doc/BRIEF.md
# Sequential configuration memory reader

This block is the read side of a cascadable store that holds a configuration bitstream and streams it to a loading device. An internal counter walks the stored array, one position per qualified rising clock edge. The current item appears on an eight-line data output, and each line has its own output enable. A mode strap selects the output format. In serial format, one bit per clock leaves on line 0, taken from each byte most-significant bit first. In parallel format, a whole byte leaves per clock on all eight lines.

The counter advances only when all of these hold: the device is selected, output is enabled, no stall is requested, and the end of the array has not yet been passed. One shared pin carries both reset and output-enable, and its active level is a build parameter. A chain-enable output lets several devices share a clock and data lines. When one device passes its last item, it releases the lines and selects the next device on the same edge, so the stream continues without a gap. A synchronous write port, honoured only while reset is asserted, loads the array.

Top module: `seqcfg_reader`

## Requirements
- R1: The counter advances by one position on a rising clock edge only when `ce_n` is low, reset is not asserted, `busy` is low and the end has not been passed.
- R2: `doe` is all zero whenever `ce_n` is high, reset is asserted, or the end has been passed; otherwise the enabled lines carry the array item at the current position.
- R3: While reset is asserted the counter returns to position zero and all lines float; after release, reading restarts at position zero.
- R4: The parameter `RST_ACTIVE_HIGH` selects the reset level of `rst_oe`: 1 (default) makes a high level reset and a low level enable output; 0 makes a low level reset and a high level enable output.
- R5: `ce_n` high clears the counter to zero, floats all lines whatever `rst_oe` is, and drives `standby` high.
- R6: `ceo_n` is low only while `ce_n` is low, reset is not asserted and the end has been passed; it goes high in the same cycle that reset asserts or `ce_n` rises.
- R7: The qualified edge after the last item sets the passed-end state. On that same edge the device floats its lines and pulls `ceo_n` low. A next device whose `ce_n` is this `ceo_n` then drives its own first item, with no gap in the stream.
- R8: With `busy` high at a rising edge the counter holds and the output data does not change.
- R9: With `par_mode` = 0 (serial) only line 0 is enabled (`doe` = 8'h01). Bits leave most-significant first, byte 0 first, and the last position is DEPTH*8-1.
- R10: With `par_mode` = 1 (parallel) all lines are enabled (`doe` = 8'hFF). Line i carries bit i of the byte, one byte per edge, and the last position is DEPTH-1.
- R11: Once the end has been passed, further edges change nothing until `ce_n` rises or reset is asserted.
- R12: A write through `wr_en`/`wr_addr`/`wr_data` stores the byte only while reset is asserted; a write at any other time has no effect on stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_oe | input | 1 | Shared reset / output-enable pin, level set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Chip select, active low; high means standby |
| busy | input | 1 | Stall request; high freezes the counter |
| par_mode | input | 1 | Output format strap: 0 serial, 1 parallel |
| wr_en | input | 1 | Array write strobe, honoured only during reset |
| wr_addr | input | $clog2(DEPTH) | Array write byte address |
| wr_data | input | 8 | Array write byte |
| dout | output | 8 | Data lines, zero where not enabled |
| doe | output | 8 | Per-line output enable; 0 means high impedance |
| ceo_n | output | 1 | Chain-enable output to the next device, active low |
| standby | output | 1 | High while the device is deselected |

## Verification
The output enables, `ceo_n` and `standby` respond to `rst_oe` and `ce_n` in the same cycle, so the bench checks them one time step after it changes those inputs. Data follows the counter, and the counter moves at the next rising edge. The bench therefore drives inputs on the falling edge and compares each item at the following falling edge, exactly one rising edge later. A clear through reset or `ce_n` takes effect at the first rising edge, so a re-read from position zero is checked after one edge of clear. The serial and parallel streams run across the boundary between two chained devices, and the bench compares every item against a pattern it computes.

// File: rtl/seqcfg_pkg.sv
`timescale 1ns/1ps
package seqcfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } out_mode_e;

  function automatic int unsigned pos_width(input int unsigned depth);
    return $clog2(depth * BYTE_W);
  endfunction
endpackage

// File: rtl/seqcfg_mem.sv
`timescale 1ns/1ps
module seqcfg_mem #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] store [DEPTH];

  // Single write port, single registered read port: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/seqcfg_addr_ctr.sv
`timescale 1ns/1ps
module seqcfg_addr_ctr
  import seqcfg_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = pos_width(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv_ok,
  input  out_mode_e     mode,
  output logic [CW-1:0] cnt,
  output logic          past,
  output logic [CW-1:0] cnt_nxt
);
  localparam logic [CW-1:0] LAST_SER = CW'(DEPTH * BYTE_W - 1);
  localparam logic [CW-1:0] LAST_PAR = CW'(DEPTH - 1);

  logic [CW-1:0] last_pos;
  logic          past_nxt;

  assign last_pos = (mode == MODE_PARALLEL) ? LAST_PAR : LAST_SER;

  always_comb begin
    cnt_nxt  = cnt;
    past_nxt = past;
    if (clr) begin
      cnt_nxt  = '0;
      past_nxt = 1'b0;
    end else if (adv_ok && !past) begin
      if (cnt == last_pos) past_nxt = 1'b1;
      else                 cnt_nxt  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    cnt  <= cnt_nxt;
    past <= past_nxt;
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk)
    clr |=> (cnt == '0 && !past)); // R3

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (clr)
    (adv_ok && !past && cnt != last_pos) |=> (cnt == $past(cnt) + 1'b1)); // R1

  AST_NO_STEP_UNQUALIFIED: assert property (@(posedge clk) disable iff (clr)
    (!adv_ok && !past) |=> ($stable(cnt) && !past)); // R1

  AST_END_FROZEN: assert property (@(posedge clk) disable iff (clr)
    past |=> (past && $stable(cnt))); // R11
endmodule

// File: rtl/seqcfg_drive.sv
`timescale 1ns/1ps
module seqcfg_drive
  import seqcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce_act,
  input  logic       oe_act,
  input  logic       past,
  input  out_mode_e  mode,
  input  logic [7:0] rd_byte,
  input  logic [2:0] bit_sel,
  output logic [7:0] dout,
  output logic [7:0] doe,
  output logic       ceo_n,
  output logic       standby
);
  logic       drive;
  logic       par;
  logic [7:0] lane_on;
  logic [7:0] lane_val;

  assign par   = (mode == MODE_PARALLEL);
  assign drive = ce_act && oe_act && !past;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
    if (i == 0) begin : g_d0
      assign lane_on[i]  = 1'b1;
      assign lane_val[i] = par ? rd_byte[0] : rd_byte[3'd7 - bit_sel];
    end else begin : g_dn
      assign lane_on[i]  = par;
      assign lane_val[i] = rd_byte[i];
    end
  end

  assign doe     = {BYTE_W{drive}} & lane_on;
  assign dout    = doe & lane_val;
  assign ceo_n   = !(ce_act && oe_act && past);
  assign standby = !ce_act;

  AST_HANDOFF_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> (doe == '0)); // R7

  AST_SERIAL_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SERIAL) |-> (doe[7:1] == '0)); // R9

  AST_STANDBY_QUIET: assert property (@(posedge clk)
    standby |-> (doe == '0 && ceo_n)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (doe == '0 && ceo_n)); // R3
endmodule

// File: rtl/seqcfg_reader.sv
`timescale 1ns/1ps
module seqcfg_reader
  import seqcfg_pkg::*;
#(
  parameter int unsigned DEPTH           = 64,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  localparam int unsigned AW             = $clog2(DEPTH),
  localparam int unsigned CW             = pos_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_oe,
  input  logic          ce_n,
  input  logic          busy,
  input  logic          par_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    dout,
  output logic [7:0]    doe,
  output logic          ceo_n,
  output logic          standby
);
  logic          rst;
  logic          oe_act;
  logic          ce_act;
  logic          clr;
  logic          adv_ok;
  out_mode_e     mode;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          past;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_byte;

  if (RST_ACTIVE_HIGH) begin : g_rst_hi
    assign rst = rst_oe;
  end else begin : g_rst_lo
    assign rst = !rst_oe;
  end

  assign oe_act = !rst;
  assign ce_act = !ce_n;
  assign clr    = rst || !ce_act;
  assign adv_ok = ce_act && oe_act && !busy;
  assign mode   = out_mode_e'(par_mode);

  seqcfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk     (clk),
    .clr     (clr),
    .adv_ok  (adv_ok),
    .mode    (mode),
    .cnt     (cnt),
    .past    (past),
    .cnt_nxt (cnt_nxt)
  );

  // Address the array with the counter's next value so the registered
  // read byte lines up with the counter in the same cycle.
  assign rd_addr = (mode == MODE_PARALLEL) ? cnt_nxt[AW-1:0] : cnt_nxt[CW-1:3];

  seqcfg_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en && rst),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_byte)
  );

  seqcfg_drive u_drive (
    .clk     (clk),
    .rst     (rst),
    .ce_act  (ce_act),
    .oe_act  (oe_act),
    .past    (past),
    .mode    (mode),
    .rd_byte (rd_byte),
    .bit_sel (cnt[2:0]),
    .dout    (dout),
    .doe     (doe),
    .ceo_n   (ceo_n),
    .standby (standby)
  );

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (clr)
    busy |=> ($stable(cnt) && $stable(dout))); // R8

  AST_CHAIN_FOLLOWS_SELECT: assert property (@(posedge clk)
    ce_n |-> ceo_n); // R6
endmodule

// File: tb/seqcfg_reader_test.sv
`timescale 1ns/1ps
module seqcfg_reader_test;
  localparam int DEPTH = 8;
  localparam int NBITS = DEPTH * 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_oe   = 1'b1;
  logic          ce_a     = 1'b0;
  logic          busy     = 1'b0;
  logic          par_mode = 1'b0;
  logic          wr_en_a  = 1'b0;
  logic          wr_en_b  = 1'b0;
  logic          wr_en_p  = 1'b0;
  logic          rst_oe_p = 1'b0;
  logic [AW-1:0] wr_addr  = '0;
  logic [7:0]    wr_data  = '0;

  logic [7:0] dout_a, doe_a, dout_b, doe_b, dout_p, doe_p;
  logic       ceo_a, ceo_b, ceo_p, stby_a, stby_b, stby_p;
  logic [7:0] bus, bus_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  seqcfg_reader #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_oe(rst_oe), .ce_n(ce_a), .busy(busy), .par_mode(par_mode),
    .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_a), .doe(doe_a), .ceo_n(ceo_a), .standby(stby_a)
  );

  seqcfg_reader #(.DEPTH(DEPTH)) uut_nxt (
    .clk(clk), .rst_oe(rst_oe), .ce_n(ceo_a), .busy(busy), .par_mode(par_mode),
    .wr_en(wr_en_b), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_b), .doe(doe_b), .ceo_n(ceo_b), .standby(stby_b)
  );

  seqcfg_reader #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b0)) uut_pol (
    .clk(clk), .rst_oe(rst_oe_p), .ce_n(1'b0), .busy(1'b0), .par_mode(par_mode),
    .wr_en(wr_en_p), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_p), .doe(doe_p), .ceo_n(ceo_p), .standby(stby_p)
  );

  assign bus    = dout_a | dout_b;
  assign bus_oe = doe_a | doe_b;

  function automatic logic [7:0] pat(input int dev, input int idx);
    return 8'((dev * 91) ^ (idx * 39) ^ 8'hC3);
  endfunction

  function automatic logic exp_bit(input int k);
    logic [7:0] b;
    int j;
    j = k % NBITS;
    b = pat(k / NBITS, j / 8);
    return b[7 - (j % 8)];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset(input logic mode);
    @(negedge clk);
    rst_oe = 1'b1; busy = 1'b0; ce_a = 1'b0; par_mode = mode;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_preload;
    hold_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = AW'(i); wr_data = pat(0, i); wr_en_a = 1'b1; wr_en_b = 1'b0;
      @(negedge clk);
      wr_data = pat(1, i); wr_en_a = 1'b0; wr_en_b = 1'b1;
      @(negedge clk);
    end
    wr_en_b = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(bus_oe == 8'h00, "R3", "lines float in reset", bus_oe, 8'h00);
    check(ceo_a == 1'b1, "R6", "chain output high in reset", ceo_a, 1);
    check(stby_b == 1'b1, "R5", "next device in standby", stby_b, 1);
    check(stby_a == 1'b0, "R5", "selected device not standby", stby_a, 0);
  endtask

  task automatic t_serial_stream;
    hold_reset(1'b0);
    rst_oe = 1'b0;
    for (int k = 0; k < 2 * NBITS; k++) begin
      #1;
      check(bus[0] == exp_bit(k), "R9", $sformatf("serial bit %0d", k), bus[0], exp_bit(k));
      check(bus_oe == 8'h01, "R9", "serial lane enable", bus_oe, 8'h01);
      check((doe_a & doe_b) == 8'h00, "R7", "no overlap at handoff", doe_a & doe_b, 0);
      if (k == NBITS) check(ceo_a == 1'b0, "R7", "handoff chain low", ceo_a, 0);
      if (k == NBITS - 1) check(ceo_a == 1'b1, "R6", "chain high before end", ceo_a, 1);
      @(negedge clk);
    end
    #1;
    check(bus_oe == 8'h00, "R2", "chain exhausted floats", bus_oe, 0);
    check(ceo_b == 1'b0, "R6", "last device chain low", ceo_b, 0);
    repeat (3) @(negedge clk);
    #1;
    check(bus_oe == 8'h00 && ceo_b == 1'b0, "R11", "end state frozen", {bus_oe, ceo_b}, 0);
  endtask

  task automatic t_busy;
    hold_reset(1'b0);
    rst_oe = 1'b0;
    for (int k = 0; k < 5; k++) begin
      #1; check(bus[0] == exp_bit(k), "R1", "pre-stall bit", bus[0], exp_bit(k));
      @(negedge clk);
    end
    busy = 1'b1;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk); #1;
      check(bus[0] == exp_bit(5), "R8", "stalled bit held", bus[0], exp_bit(5));
    end
    busy = 1'b0;
    for (int k = 5; k < 20; k++) begin
      #1; check(bus[0] == exp_bit(k), "R8", "post-stall bit", bus[0], exp_bit(k));
      @(negedge clk);
    end
  endtask

  task automatic t_parallel;
    hold_reset(1'b1);
    rst_oe = 1'b0;
    for (int k = 0; k < 2 * DEPTH; k++) begin
      #1;
      check(bus == pat(k / DEPTH, k % DEPTH), "R10", $sformatf("byte %0d", k), bus, pat(k / DEPTH, k % DEPTH));
      check(bus_oe == 8'hFF, "R10", "all lanes enabled", bus_oe, 8'hFF);
      @(negedge clk);
    end
    #1;
    check(bus_oe == 8'h00, "R7", "parallel chain exhausted", bus_oe, 0);
  endtask

  task automatic t_oe_drop;
    hold_reset(1'b1);
    rst_oe = 1'b0;
    repeat (DEPTH + 2) @(negedge clk);
    #1;
    check(ceo_a == 1'b0, "R6", "chain low after end", ceo_a, 0);
    check(bus == pat(1, 2), "R7", "next device byte 2", bus, pat(1, 2));
    rst_oe = 1'b1;
    #1;
    check(ceo_a == 1'b1, "R6", "chain high on OE drop", ceo_a, 1);
    check(bus_oe == 8'h00, "R2", "float on OE drop", bus_oe, 0);
    @(negedge clk);
    rst_oe = 1'b0;
    #1;
    check(bus == pat(0, 0), "R3", "re-read from zero", bus, pat(0, 0));
    @(negedge clk); #1;
    check(bus == pat(0, 1), "R3", "re-read second byte", bus, pat(0, 1));
  endtask

  task automatic t_standby;
    hold_reset(1'b1);
    rst_oe = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(bus == pat(0, 3), "R1", "byte 3 before deselect", bus, pat(0, 3));
    ce_a = 1'b1;
    #1;
    check(stby_a == 1'b1, "R5", "standby flag", stby_a, 1);
    check(doe_a == 8'h00, "R5", "deselected floats", doe_a, 0);
    check(ceo_a == 1'b1, "R6", "chain high on deselect", ceo_a, 1);
    @(negedge clk);
    ce_a = 1'b0;
    #1;
    check(bus == pat(0, 0), "R5", "reselect restarts at zero", bus, pat(0, 0));
    check(stby_a == 1'b0, "R5", "standby cleared", stby_a, 0);
  endtask

  task automatic t_write_gate;
    hold_reset(1'b1);
    rst_oe = 1'b0;
    wr_addr = '0; wr_data = ~pat(0, 0); wr_en_a = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0;
    hold_reset(1'b1);
    rst_oe = 1'b0;
    #1;
    check(bus == pat(0, 0), "R12", "write outside reset ignored", bus, pat(0, 0));
    hold_reset(1'b1);
    wr_addr = '0; wr_data = 8'h3C; wr_en_a = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0;
    repeat (2) @(negedge clk);
    rst_oe = 1'b0;
    #1;
    check(bus == 8'h3C, "R12", "write during reset stored", bus, 8'h3C);
    hold_reset(1'b1);
    wr_data = pat(0, 0); wr_en_a = 1'b1;
    @(negedge clk);
    wr_en_a = 1'b0;
  endtask

  task automatic t_polarity;
    @(negedge clk);
    par_mode = 1'b0; rst_oe_p = 1'b0;
    wr_addr = '0; wr_data = 8'h80; wr_en_p = 1'b1;
    @(negedge clk);
    wr_en_p = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(doe_p == 8'h00, "R4", "low level resets", doe_p, 0);
    rst_oe_p = 1'b1;
    #1;
    check(doe_p == 8'h01, "R4", "high level enables", doe_p, 8'h01);
    check(dout_p[0] == 1'b1, "R4", "first bit msb", dout_p[0], 1);
    @(negedge clk); #1;
    check(dout_p[0] == 1'b0, "R9", "second bit", dout_p[0], 0);
    rst_oe_p = 1'b0;
  endtask

  initial begin
    t_preload();
    t_serial_stream();
    t_busy();
    t_parallel();
    t_oe_drop();
    t_standby();
    t_write_gate();
    t_polarity();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule